// File: doc/BRIEF.md
# Microcontroller Memory Window Remapper

This block sits between the 16-bit address bus of a small 8-bit microcontroller core and a 32-bit system bus. Each request carries a CPU address and a kind (code fetch or data access). The block answers one clock later with the 32-bit system address and a tag naming the memory window that was chosen.

Code fetches go either to an internal program window in on-chip SRAM or to an external program window. A boot-select bit picks the rule. With internal program memory enabled, low addresses stay internal and anything at or past the internal size falls through to the external window. With it disabled, every fetch goes external. Data accesses always land in the external data window. That window's base is the sum of two terms: a 21-bit register offset at 2 KB granularity and a 16-bit page value, built from two special-register bytes, at 64 KB granularity. A global mapping enable must be set for any of this to apply. While it is clear, the CPU address passes through zero-extended.

Top module: `mcu_addr_remap`

## Requirements
- R1: After reset `out_valid` is 0, `out_addr` is 0 and `out_win` is 0. From then on, `out_valid` equals `req_valid` one clock earlier, and `out_addr`/`out_win` show the translation of the request presented one clock earlier.
- R2: A clock with `req_valid` low leaves `out_addr` and `out_win` unchanged, whatever the other inputs do.
- R3: `out_win` encodes 0 = no mapping, 1 = internal program window, 2 = external program window, 3 = external data window.
- R4: With `map_en` = 0 every request gives `out_win` = 0 and `out_addr` = the CPU address zero-extended to 32 bits.
- R5: A code fetch (`req_kind` = 0) with `map_en` = 1, `boot_int` = 1 and address below 0x2000 (8 KB) gives window 1 at 0x0520_0000 + `irom_ofs`·2048 + address.
- R6: A code fetch with `map_en` = 1, `boot_int` = 1 and address 0x2000 or above gives window 2 at `xrom_ofs`·2048 + address.
- R7: A code fetch with `map_en` = 1 and `boot_int` = 0 gives window 2 at `xrom_ofs`·2048 + address for every address, including 0.
- R8: A data access (`req_kind` = 1) with `map_en` = 1 gives window 3 at `xram_ofs`·2048 + {`page_hi`,`page_lo`}·65536 + address, independent of `boot_int`.
- R9: All sums are taken modulo 2^32. A carry out of bit 31 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 1 | 0 = code fetch, 1 = data access |
| cpu_addr | input | 16 | CPU address |
| map_en | input | 1 | Global mapping enable |
| boot_int | input | 1 | 1 = fetch from internal program memory first |
| irom_ofs | input | 5 | Internal program window offset, 2 KB units |
| xrom_ofs | input | 21 | External program window offset, 2 KB units |
| xram_ofs | input | 21 | External data window offset, 2 KB units |
| page_lo | input | 8 | Low byte of the data page, 64 KB units |
| page_hi | input | 8 | High byte of the data page, 64 KB units |
| out_valid | output | 1 | Translated result valid |
| out_addr | output | 32 | Translated system address |
| out_win | output | 2 | Chosen window tag |

## Verification
The assertions assume that reset is held low from time zero until the first inputs are driven. They also assume that every input is a known level at each rising edge; the configuration may change on any cycle. The bench changes all inputs only at the falling edge and holds them stable through the next rising edge. Random draws cover every field across its full range, so the boot-select threshold, the enable and the modulo carry are all reached. Directed cases pin the addresses 0x1FFF and 0x2000 and the all-ones data base.

// File: rtl/mar_pkg.sv
package mar_pkg;
   typedef enum logic [1:0] {
      WIN_NONE = 2'd0,
      WIN_IROM = 2'd1,
      WIN_XROM = 2'd2,
      WIN_XRAM = 2'd3
   } mar_win_e;

   typedef enum logic {
      KIND_CODE = 1'b0,
      KIND_DATA = 1'b1
   } mar_kind_e;
endpackage

// File: rtl/mar_code_map.sv
module mar_code_map
   import mar_pkg::*;
#(
   parameter int CPU_AW     = 16,
   parameter int SYS_AW     = 32,
   parameter int OFS_W      = 21,
   parameter int IOFS_W     = 5,
   parameter int GRAN_LG    = 11,
   parameter int IROM_BYTES = 8192,
   parameter logic [31:0] IROM_BASE = 32'h0520_0000
) (
   input  logic [CPU_AW-1:0] addr,
   input  logic              boot_int,
   input  logic [IOFS_W-1:0] irom_ofs,
   input  logic [OFS_W-1:0]  xrom_ofs,
   output logic [SYS_AW-1:0] sys_addr,
   output mar_win_e          win
);
   localparam logic [SYS_AW-1:0] IBASE_SYS = SYS_AW'(IROM_BASE);
   localparam logic [CPU_AW:0]   IROM_LIM  = (CPU_AW+1)'(IROM_BYTES);

   logic [SYS_AW-1:0] addr_ext;
   logic [SYS_AW-1:0] xrom_base;
   logic [SYS_AW-1:0] xrom_addr;

   assign addr_ext  = {{(SYS_AW-CPU_AW){1'b0}}, addr};
   assign xrom_base = {{(SYS_AW-OFS_W){1'b0}}, xrom_ofs} << GRAN_LG;
   assign xrom_addr = xrom_base + addr_ext;

   generate
      if (IROM_BYTES == 0) begin : g_no_irom
         assign sys_addr = xrom_addr;
         assign win      = WIN_XROM;
      end else begin : g_irom
         logic              in_irom;
         logic [SYS_AW-1:0] irom_base;
         logic [SYS_AW-1:0] irom_addr;

         assign in_irom   = boot_int && ({1'b0, addr} < IROM_LIM);
         assign irom_base = IBASE_SYS
                          + ({{(SYS_AW-IOFS_W){1'b0}}, irom_ofs} << GRAN_LG);
         assign irom_addr = irom_base + addr_ext;

         always_comb begin
            if (in_irom) begin
               sys_addr = irom_addr;
               win      = WIN_IROM;
            end else begin
               sys_addr = xrom_addr;
               win      = WIN_XROM;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/mar_data_map.sv
module mar_data_map #(
   parameter int CPU_AW  = 16,
   parameter int SYS_AW  = 32,
   parameter int OFS_W   = 21,
   parameter int GRAN_LG = 11,
   parameter int PAGE_W  = 16,
   parameter int PAGE_LG = 16
) (
   input  logic [CPU_AW-1:0] addr,
   input  logic [OFS_W-1:0]  xram_ofs,
   input  logic [PAGE_W-1:0] page,
   output logic [SYS_AW-1:0] sys_addr
);
   logic [SYS_AW-1:0] reg_base;
   logic [SYS_AW-1:0] page_base;

   assign reg_base  = {{(SYS_AW-OFS_W){1'b0}}, xram_ofs} << GRAN_LG;
   assign page_base = {{(SYS_AW-PAGE_W){1'b0}}, page} << PAGE_LG;
   assign sys_addr  = reg_base + page_base + {{(SYS_AW-CPU_AW){1'b0}}, addr};
endmodule

// File: rtl/mar_out_stage.sv
module mar_out_stage
   import mar_pkg::*;
#(
   parameter int SYS_AW = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [SYS_AW-1:0] nxt_addr,
   input  mar_win_e          nxt_win,
   output logic              q_valid,
   output logic [SYS_AW-1:0] q_addr,
   output mar_win_e          q_win
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_addr  <= '0;
         q_win   <= WIN_NONE;
      end else begin
         q_valid <= load;
         if (load) begin
            q_addr <= nxt_addr;
            q_win  <= nxt_win;
         end
      end
   end
endmodule

// File: rtl/mcu_addr_remap.sv
module mcu_addr_remap
   import mar_pkg::*;
#(
   parameter int CPU_AW     = 16,
   parameter int SYS_AW     = 32,
   parameter int OFS_W      = 21,
   parameter int IOFS_W     = 5,
   parameter int GRAN_LG    = 11,
   parameter int PAGE_LG    = 16,
   parameter int IROM_BYTES = 8192,
   parameter logic [31:0] IROM_BASE = 32'h0520_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_kind,
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic              map_en,
   input  logic              boot_int,
   input  logic [IOFS_W-1:0] irom_ofs,
   input  logic [OFS_W-1:0]  xrom_ofs,
   input  logic [OFS_W-1:0]  xram_ofs,
   input  logic [7:0]        page_lo,
   input  logic [7:0]        page_hi,
   output logic              out_valid,
   output logic [SYS_AW-1:0] out_addr,
   output logic [1:0]        out_win
);
   localparam int PAGE_W = 16;

   generate
      if (SYS_AW < CPU_AW || SYS_AW < OFS_W + 1 || SYS_AW > 32) begin : g_bad_aw
         $error("mcu_addr_remap: SYS_AW out of range");
      end
      if (IROM_BYTES < 0 || IROM_BYTES > (1 << CPU_AW)) begin : g_bad_irom
         $error("mcu_addr_remap: IROM_BYTES exceeds CPU space");
      end
      if (GRAN_LG >= SYS_AW || PAGE_LG >= SYS_AW) begin : g_bad_gran
         $error("mcu_addr_remap: granularity too coarse");
      end
   endgenerate

   logic [SYS_AW-1:0] code_addr;
   mar_win_e          code_win;
   logic [SYS_AW-1:0] data_addr;
   logic [SYS_AW-1:0] sel_addr;
   mar_win_e          sel_win;
   mar_win_e          q_win;

   mar_code_map #(
      .CPU_AW(CPU_AW), .SYS_AW(SYS_AW), .OFS_W(OFS_W), .IOFS_W(IOFS_W),
      .GRAN_LG(GRAN_LG), .IROM_BYTES(IROM_BYTES), .IROM_BASE(IROM_BASE)
   ) u_code (
      .addr(cpu_addr), .boot_int(boot_int), .irom_ofs(irom_ofs),
      .xrom_ofs(xrom_ofs), .sys_addr(code_addr), .win(code_win)
   );

   mar_data_map #(
      .CPU_AW(CPU_AW), .SYS_AW(SYS_AW), .OFS_W(OFS_W), .GRAN_LG(GRAN_LG),
      .PAGE_W(PAGE_W), .PAGE_LG(PAGE_LG)
   ) u_data (
      .addr(cpu_addr), .xram_ofs(xram_ofs), .page({page_hi, page_lo}),
      .sys_addr(data_addr)
   );

   always_comb begin
      if (!map_en) begin
         sel_addr = {{(SYS_AW-CPU_AW){1'b0}}, cpu_addr};
         sel_win  = WIN_NONE;
      end else if (req_kind == KIND_DATA) begin
         sel_addr = data_addr;
         sel_win  = WIN_XRAM;
      end else begin
         sel_addr = code_addr;
         sel_win  = code_win;
      end
   end

   mar_out_stage #(.SYS_AW(SYS_AW)) u_out (
      .clk(clk), .rst_n(rst_n), .load(req_valid),
      .nxt_addr(sel_addr), .nxt_win(sel_win),
      .q_valid(out_valid), .q_addr(out_addr), .q_win(q_win)
   );

   assign out_win = q_win;
endmodule

// File: rtl/mar_remap_chk.sv
module mar_remap_chk #(
   parameter int CPU_AW     = 16,
   parameter int SYS_AW     = 32,
   parameter int OFS_W      = 21,
   parameter int IOFS_W     = 5,
   parameter int GRAN_LG    = 11,
   parameter int IROM_BYTES = 8192,
   parameter logic [31:0] IROM_BASE = 32'h0520_0000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_kind,
   input logic [CPU_AW-1:0] cpu_addr,
   input logic              map_en,
   input logic              boot_int,
   input logic [IOFS_W-1:0] irom_ofs,
   input logic [OFS_W-1:0]  xrom_ofs,
   input logic [SYS_AW-1:0] out_addr,
   input logic              out_valid,
   input logic [1:0]        out_win
);
   assert_valid_lag_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid);
   assert_idle_lag_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !out_valid);
   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(out_addr) && $stable(out_win)));
   assert_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !map_en) |=>
         (out_win == 2'd0 && out_addr == SYS_AW'($past(cpu_addr))));
   assert_data_win_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && map_en && req_kind) |=> out_win == 2'd3);
   assert_ext_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && map_en && !req_kind && !boot_int) |=>
         (out_win == 2'd2 &&
          out_addr == (SYS_AW'($past(xrom_ofs)) << GRAN_LG) + SYS_AW'($past(cpu_addr))));
   assert_irom_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && map_en && !req_kind && boot_int && (32'(cpu_addr) < IROM_BYTES)) |=>
         (out_win == 2'd1 &&
          out_addr - (SYS_AW'(IROM_BASE) + (SYS_AW'($past(irom_ofs)) << GRAN_LG))
             < SYS_AW'(IROM_BYTES)));
   assert_fallthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && map_en && !req_kind && boot_int && (32'(cpu_addr) >= IROM_BYTES)) |=>
         out_win == 2'd2);
   assert_win_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_win != 2'd0 || $past(!map_en)));
endmodule

bind mcu_addr_remap mar_remap_chk #(
   .CPU_AW(CPU_AW), .SYS_AW(SYS_AW), .OFS_W(OFS_W), .IOFS_W(IOFS_W),
   .GRAN_LG(GRAN_LG), .IROM_BYTES(IROM_BYTES), .IROM_BASE(IROM_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
   .cpu_addr(cpu_addr), .map_en(map_en), .boot_int(boot_int),
   .irom_ofs(irom_ofs), .xrom_ofs(xrom_ofs), .out_addr(out_addr),
   .out_valid(out_valid), .out_win(out_win)
);

// File: tb/mcu_addr_remap_test.sv
`timescale 1ns/1ps
module mcu_addr_remap_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_kind = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        map_en = 1'b0;
   logic        boot_int = 1'b0;
   logic [4:0]  irom_ofs = '0;
   logic [20:0] xrom_ofs = '0;
   logic [20:0] xram_ofs = '0;
   logic [7:0]  page_lo = '0;
   logic [7:0]  page_hi = '0;
   logic        out_valid;
   logic [31:0] out_addr;
   logic [1:0]  out_win;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   mcu_addr_remap uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .cpu_addr(cpu_addr), .map_en(map_en), .boot_int(boot_int),
      .irom_ofs(irom_ofs), .xrom_ofs(xrom_ofs), .xram_ofs(xram_ofs),
      .page_lo(page_lo), .page_hi(page_hi), .out_valid(out_valid),
      .out_addr(out_addr), .out_win(out_win)
   );

   function automatic logic [31:0] exp_addr();
      if (!map_en) return {16'h0, cpu_addr};
      if (req_kind)
         return ({11'h0, xram_ofs} << 11) + ({page_hi, page_lo, 16'h0}) + {16'h0, cpu_addr};
      if (boot_int && cpu_addr < 16'h2000)
         return 32'h0520_0000 + ({27'h0, irom_ofs} << 11) + {16'h0, cpu_addr};
      return ({11'h0, xrom_ofs} << 11) + {16'h0, cpu_addr};
   endfunction

   function automatic logic [1:0] exp_win();
      if (!map_en) return 2'd0;
      if (req_kind) return 2'd3;
      if (boot_int && cpu_addr < 16'h2000) return 2'd1;
      return 2'd2;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive at falling edge, result sampled at the next falling edge
   task automatic xlate(string req);
      logic [31:0] ea;
      logic [1:0]  ew;
      req_valid = 1'b1;
      ea = exp_addr();
      ew = exp_win();
      @(negedge clk);
      check({req, " addr"}, out_addr, ea);
      check({req, " win"},  {30'h0, out_win}, {30'h0, ew});
      check({req, " valid"}, {31'h0, out_valid}, 32'h1);
   endtask

   task automatic set_cfg(bit en, bit kind, bit boot, logic [15:0] a);
      map_en = en; req_kind = kind; boot_int = boot; cpu_addr = a;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] held_a;
      logic [1:0]  held_w;
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 reset valid", {31'h0, out_valid}, 32'h0);
      check("R1 reset addr", out_addr, 32'h0);
      check("R1 reset win", {30'h0, out_win}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      irom_ofs = 5'd3; xrom_ofs = 21'h00123; xram_ofs = 21'h00040;
      page_lo = 8'h02; page_hi = 8'h00;
      set_cfg(1, 0, 1, 16'h1FFF); xlate("R5 last internal byte");
      set_cfg(1, 0, 1, 16'h0000); xlate("R5 internal start");
      set_cfg(1, 0, 1, 16'h2000); xlate("R6 first fall-through");
      set_cfg(1, 0, 1, 16'hFFFF); xlate("R6 top fall-through");
      set_cfg(1, 0, 0, 16'h0000); xlate("R7 external boot at 0");
      set_cfg(1, 0, 0, 16'h1FFF); xlate("R7 external low addr");
      set_cfg(1, 1, 0, 16'h0010); xlate("R8 data boot clear");
      set_cfg(1, 1, 1, 16'h0010); xlate("R8 data boot set");
      set_cfg(0, 0, 1, 16'h1234); xlate("R4 bypass code");
      set_cfg(0, 1, 0, 16'hBEEF); xlate("R4 bypass data");
      // R9 carry out of bit 31 dropped
      xram_ofs = 21'h1FFFFF; page_lo = 8'hFF; page_hi = 8'hFF;
      set_cfg(1, 1, 0, 16'hFFFF); xlate("R9 data wrap");
      xrom_ofs = 21'h1FFFFF;
      set_cfg(1, 0, 0, 16'hFFFF); xlate("R9 code wrap");
      // R3 encoding against a fixed expected tag
      set_cfg(1, 0, 1, 16'h0100);
      req_valid = 1'b1;
      @(negedge clk);
      check("R3 internal tag is 1", {30'h0, out_win}, 32'd1);

      // R2 hold with idle request while inputs move
      held_a = out_addr; held_w = out_win;
      req_valid = 1'b0;
      set_cfg(1, 1, 0, 16'h7777); xram_ofs = 21'h0ABCD;
      @(negedge clk);
      check("R2 hold addr", out_addr, held_a);
      check("R2 hold win", {30'h0, out_win}, {30'h0, held_w});
      check("R1 idle valid", {31'h0, out_valid}, 32'h0);
      set_cfg(0, 0, 0, 16'h0001);
      @(negedge clk);
      check("R2 hold addr again", out_addr, held_a);

      // random mix, R1 R3 R4 R5 R6 R7 R8 R9
      for (int i = 0; i < 3000; i++) begin
         map_en   = ($urandom % 8) != 0;
         req_kind = $urandom % 2;
         boot_int = $urandom % 2;
         cpu_addr = 16'($urandom);
         irom_ofs = 5'($urandom);
         xrom_ofs = 21'($urandom);
         xram_ofs = 21'($urandom);
         page_lo  = 8'($urandom);
         page_hi  = 8'($urandom);
         if (($urandom % 5) == 0) begin
            held_a = out_addr; held_w = out_win;
            req_valid = 1'b0;
            @(negedge clk);
            check("R2 random idle addr", out_addr, held_a);
            check("R1 random idle valid", {31'h0, out_valid}, 32'h0);
         end else begin
            xlate("R8 R5 R6 R7 random");
         end
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule